// File: doc/BRIEF.md
# Host register and buffer port

This block gives a host processor byte-wide access to the configuration and data store of a serial audio transmitter. A 32-location space is reached through a chip-select-qualified parallel port. Location 0 is a read-only status byte. Locations 1 to 3 are control bytes. Locations 4 to 31 form a 28-byte buffer that holds the channel-status, user and auxiliary bytes the transmitter sends. The bidirectional host data bus is split into an input bus, an output bus and an output-enable, so that a pad ring can join them.

A second, read-only port serves the transmitter. The transmitter names a buffer index and receives that byte one cycle later. The block records which third of the buffer the transmitter last fetched from and shows this in the status byte. The host polls this flag and refills the part of the buffer that the transmitter is not using. Control byte 2 holds the run and unmute bits, which release the transmitter only when both are set, and a two-bit buffer-mode field with three legal codes.

Top module: `host_buf_port`

## Requirements
- R1: Address 0 selects the status byte, addresses 1, 2 and 3 select control bytes 0, 1 and 2, and address A from 4 to 31 selects buffer byte A-4.
- R2: An access takes place on a rising clock edge at which `cs_n` is low. With `rw` = 0, `din` is written to the addressed location. With `rw` = 1, the location's value appears on `dout` in the following cycle and `dout_oe` is high for exactly that cycle. While `cs_n` is high, no location changes and `dout_oe` stays low.
- R3: Reset sets all three control bytes to zero, so `tx_enable` = 0 and `tx_mode` = 0. It also clears the status flags, `dout_oe` and `tx_data` to zero.
- R4: `tx_enable` is 1 only while both bit 0 (run) and bit 1 (unmute) of control byte 2 are 1.
- R5: Bits [3:2] of control byte 2 form the buffer mode and drive `tx_mode`. Codes 0, 1 and 2 are stored. A write that carries code 3 leaves the mode field unchanged but still writes the other bits of the byte.
- R6: The status byte is read-only. Host writes to address 0 change nothing.
- R7: Status bits [2:0] are one-hot and show the region of the last valid fetch: bit 0 for indices 0 to 8, bit 1 for indices 9 to 17, bit 2 for indices 18 to 27. Bits [7:3] always read zero. All bits read zero until the first fetch after reset.
- R8: When `tx_rd_en` is high with `tx_idx` < 28, buffer byte `tx_idx` appears on `tx_data` in the next cycle and stays there until the next valid fetch.
- R9: If a host write and a fetch address the same buffer byte in the same cycle, the fetch returns the newly written value.
- R10: A fetch with `tx_idx` of 28 or more is ignored: `tx_data` and the status flags hold their values.
- R11: Reset does not clear the buffer. Bytes written before a reset read back unchanged after it.
- R12: `cfg0` and `cfg1` always show the stored values of control bytes 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Host chip select, active low |
| rw | input | 1 | 1 = host read, 0 = host write |
| addr | input | 5 | Host byte address |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data |
| dout_oe | output | 1 | Drive enable for `dout` |
| tx_rd_en | input | 1 | Transmitter fetch request |
| tx_idx | input | 5 | Buffer index to fetch |
| tx_data | output | 8 | Fetched buffer byte |
| tx_enable | output | 1 | Transmitter released from reset and unmuted |
| tx_mode | output | 2 | Buffer-mode field |
| cfg0 | output | 8 | Control byte 0 |
| cfg1 | output | 8 | Control byte 1 |

## Verification
The hardest case to reach is the same-cycle collision: a host write and a transmitter fetch must target the same buffer byte on the same edge. Random traffic seldom lines the two indices up. The stimulus therefore includes directed cycles that write address 4+k while fetching index k. It also includes a random phase whose fetch index is drawn from the host's own write address about half of the time. Other directed steps write the reserved mode code, write to the status address during a fetch, fetch past the end of the buffer, and reset with a full buffer to show the contents survive.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

    typedef enum logic [1:0] {
        MODE_LINEAR = 2'd0,
        MODE_SPLIT  = 2'd1,
        MODE_RING   = 2'd2,
        MODE_RSVD   = 2'd3
    } buf_mode_e;

    // One-hot region flag for a fetch index within a buffer of n bytes
    function automatic logic [2:0] region_flags(input int idx, input int n);
        if (idx < n / 3)
            return 3'b001;
        else if (idx < (2 * n) / 3)
            return 3'b010;
        else
            return 3'b100;
    endfunction

endpackage

// File: rtl/hbp_regs.sv
module hbp_regs
    import hbp_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int N_CTRL    = 3,
    parameter int BUF_BYTES = 28,
    parameter int IDX_W     = 5,
    parameter int CSEL_W    = 2,
    parameter int MODE_REG  = 2,
    parameter int MODE_LSB  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ctrl_we,
    input  logic [CSEL_W-1:0]        ctrl_sel,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     fetch_ok,
    input  logic [IDX_W-1:0]         fetch_idx,
    output logic [N_CTRL-1:0][DATA_W-1:0] ctrl,
    output logic [DATA_W-1:0]        status
);

    typedef struct packed {
        logic [N_CTRL-1:0][DATA_W-1:0] ctrl;
        logic [2:0]                    flags;
    } regs_t;

    regs_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (ctrl_we && int'(ctrl_sel) < N_CTRL) begin
            state_d.ctrl[ctrl_sel] = wdata;
            if (int'(ctrl_sel) == MODE_REG &&
                wdata[MODE_LSB+:2] == MODE_RSVD) begin
                state_d.ctrl[ctrl_sel][MODE_LSB+:2] = state_q.ctrl[MODE_REG][MODE_LSB+:2];
            end
        end
        if (fetch_ok) begin
            state_d.flags = region_flags(int'(fetch_idx), BUF_BYTES);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ctrl   = state_q.ctrl;
    assign status = {{(DATA_W-3){1'b0}}, state_q.flags};

    // R5
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && int'(ctrl_sel) == MODE_REG && wdata[MODE_LSB+:2] == 2'b11)
        |=> $stable(state_q.ctrl[MODE_REG][MODE_LSB+:2]));

    // R7
    status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status));

endmodule

// File: rtl/hbp_buffer.sv
module hbp_buffer #(
    parameter int DATA_W    = 8,
    parameter int BUF_BYTES = 28,
    parameter int IDX_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  host_idx,
    output logic [DATA_W-1:0] host_data,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [BUF_BYTES];
    logic [DATA_W-1:0] rd_data_d, rd_data_q;

    // Storage keeps its contents through reset
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign host_data = mem[host_idx];

    always_comb begin
        rd_data_d = rd_data_q;
        if (rd_en) begin
            if (wr_en && wr_idx == rd_idx)
                rd_data_d = wr_data;
            else
                rd_data_d = mem[rd_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q <= '0;
        end else begin
            rd_data_q <= rd_data_d;
        end
    end

    assign rd_data = rd_data_q;

    // R9
    write_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en && wr_idx == rd_idx) |=> rd_data == $past(wr_data));

endmodule

// File: rtl/host_buf_port.sv
module host_buf_port
    import hbp_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 5,
    parameter int N_CTRL    = 3,
    parameter int BUF_BYTES = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    input  logic              tx_rd_en,
    input  logic [ADDR_W-1:0] tx_idx,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_enable,
    output logic [1:0]        tx_mode,
    output logic [DATA_W-1:0] cfg0,
    output logic [DATA_W-1:0] cfg1
);

    localparam int BUF_BASE = N_CTRL + 1;
    localparam int IDX_W    = $clog2(BUF_BYTES);
    localparam int CSEL_W   = (N_CTRL > 1) ? $clog2(N_CTRL) : 1;
    localparam int MODE_REG = 2;
    localparam int MODE_LSB = 2;

    typedef struct packed {
        logic [DATA_W-1:0] dout;
        logic              oe;
    } host_out_t;

    host_out_t out_d, out_q;

    logic host_rd, host_wr;
    logic is_stat, is_ctrl, is_buf;
    logic [CSEL_W-1:0] ctrl_sel;
    logic [IDX_W-1:0]  buf_idx;
    logic [IDX_W-1:0]  fetch_idx;
    logic              fetch_ok;
    logic [N_CTRL-1:0][DATA_W-1:0] ctrl;
    logic [DATA_W-1:0] status;
    logic [DATA_W-1:0] buf_rdata;

    assign host_rd   = !cs_n && rw;
    assign host_wr   = !cs_n && !rw;
    assign is_stat   = (int'(addr) == 0);
    assign is_ctrl   = (int'(addr) >= 1) && (int'(addr) <= N_CTRL);
    assign is_buf    = (int'(addr) >= BUF_BASE) && (int'(addr) < BUF_BASE + BUF_BYTES);
    assign ctrl_sel  = CSEL_W'(int'(addr) - 1);
    assign buf_idx   = IDX_W'(int'(addr) - BUF_BASE);
    assign fetch_ok  = tx_rd_en && (int'(tx_idx) < BUF_BYTES);
    assign fetch_idx = IDX_W'(tx_idx);

    hbp_regs #(
        .DATA_W(DATA_W), .N_CTRL(N_CTRL), .BUF_BYTES(BUF_BYTES), .IDX_W(IDX_W),
        .CSEL_W(CSEL_W), .MODE_REG(MODE_REG), .MODE_LSB(MODE_LSB)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_we  (host_wr && is_ctrl),
        .ctrl_sel (ctrl_sel),
        .wdata    (din),
        .fetch_ok (fetch_ok),
        .fetch_idx(fetch_idx),
        .ctrl     (ctrl),
        .status   (status)
    );

    hbp_buffer #(
        .DATA_W(DATA_W), .BUF_BYTES(BUF_BYTES), .IDX_W(IDX_W)
    ) u_buffer (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (host_wr && is_buf),
        .wr_idx   (buf_idx),
        .wr_data  (din),
        .host_idx (buf_idx),
        .host_data(buf_rdata),
        .rd_en    (fetch_ok),
        .rd_idx   (fetch_idx),
        .rd_data  (tx_data)
    );

    always_comb begin
        out_d      = out_q;
        out_d.oe   = host_rd;
        if (host_rd) begin
            if (is_stat)
                out_d.dout = status;
            else if (is_ctrl)
                out_d.dout = ctrl[ctrl_sel];
            else if (is_buf)
                out_d.dout = buf_rdata;
            else
                out_d.dout = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign dout      = out_q.dout;
    assign dout_oe   = out_q.oe;
    assign tx_enable = ctrl[MODE_REG][0] & ctrl[MODE_REG][1];
    assign tx_mode   = ctrl[MODE_REG][MODE_LSB+:2];
    assign cfg0      = ctrl[0];
    assign cfg1      = ctrl[1];

    // R2
    oe_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> $past(!cs_n && rw));

    // R6
    status_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && is_stat && !tx_rd_en) |=> $stable(status));

endmodule

// File: tb/host_buf_port_bench.sv
module host_buf_port_bench;

    localparam int NB = 28;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       rw = 1'b1;
    logic [4:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       dout_oe;
    logic       tx_rd_en = 1'b0;
    logic [4:0] tx_idx = '0;
    logic [7:0] tx_data;
    logic       tx_enable;
    logic [1:0] tx_mode;
    logic [7:0] cfg0, cfg1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    logic [7:0] m_ctrl [3];
    logic [2:0] m_flags;
    logic [7:0] m_buf [NB];
    bit         m_known [NB];
    logic [7:0] e_dout;
    bit         e_oe;
    bit         e_dout_known;
    logic [7:0] e_tx;
    bit         e_tx_known;
    string      e_rd_tag;

    always #2 clk = ~clk;

    host_buf_port u_host_buf_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .addr(addr), .din(din),
        .dout(dout), .dout_oe(dout_oe), .tx_rd_en(tx_rd_en), .tx_idx(tx_idx),
        .tx_data(tx_data), .tx_enable(tx_enable), .tx_mode(tx_mode),
        .cfg0(cfg0), .cfg1(cfg1)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] ref_region(input int i);
        if (i <= 8) return 3'b001;
        if (i <= 17) return 3'b010;
        return 3'b100;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 3; i++) m_ctrl[i] = 8'h00;
        m_flags = 3'b000;
        e_oe = 1'b0;
        e_tx = 8'h00;
        e_tx_known = 1'b1;
        e_dout_known = 1'b0;
    endtask

    task automatic model_step(input bit c, input bit r, input int a, input logic [7:0] d,
                              input bit fe, input int fi);
        e_oe = !c && r;
        if (!c && r) begin
            e_dout_known = 1'b1;
            if (a == 0) begin
                e_dout = {5'b0, m_flags}; e_rd_tag = "R7 status read";
            end else if (a <= 3) begin
                e_dout = m_ctrl[a-1]; e_rd_tag = "R1 control read";
            end else begin
                e_dout = m_buf[a-4]; e_dout_known = m_known[a-4];
                e_rd_tag = "R1 buffer read";
            end
        end
        if (!c && !r) begin
            if (a >= 1 && a <= 3) begin
                if (a == 3 && d[3:2] == 2'b11)
                    m_ctrl[2] = {d[7:4], m_ctrl[2][3:2], d[1:0]};
                else
                    m_ctrl[a-1] = d;
            end else if (a >= 4) begin
                m_buf[a-4] = d;
                m_known[a-4] = 1'b1;
            end
        end
        if (fe && fi < NB) begin
            e_tx = m_buf[fi];
            e_tx_known = m_known[fi];
            m_flags = ref_region(fi);
        end
    endtask

    task automatic compare_all();
        check("R2 dout_oe", {7'b0, dout_oe}, {7'b0, e_oe});
        if (e_oe && e_dout_known) check(e_rd_tag, dout, e_dout);
        if (e_tx_known) check("R8 tx_data", tx_data, e_tx);
        check("R4 tx_enable", {7'b0, tx_enable}, {7'b0, m_ctrl[2][0] & m_ctrl[2][1]});
        check("R5 tx_mode", {6'b0, tx_mode}, {6'b0, m_ctrl[2][3:2]});
        check("R12 cfg0", cfg0, m_ctrl[0]);
        check("R12 cfg1", cfg1, m_ctrl[1]);
    endtask

    // One clock: drive at the falling edge, model after the rising edge, compare at the next falling edge
    task automatic cyc(input bit c, input bit r, input int a, input logic [7:0] d,
                       input bit fe, input int fi);
        cs_n = c; rw = r; addr = 5'(a); din = d; tx_rd_en = fe; tx_idx = 5'(fi);
        @(posedge clk);
        #1;
        model_step(c, r, a, d, fe, fi);
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        cyc(1'b0, 1'b0, a, d, 1'b0, 0);
    endtask

    task automatic rd(input int a);
        cyc(1'b0, 1'b1, a, 8'h00, 1'b0, 0);
    endtask

    task automatic fetch(input int i);
        cyc(1'b1, 1'b1, 0, 8'h00, 1'b1, i);
    endtask

    task automatic do_reset();
        cs_n = 1'b1; tx_rd_en = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < NB; i++) begin m_known[i] = 1'b0; m_buf[i] = 8'h00; end
        model_reset();
        @(negedge clk);
        do_reset();
        // R3: reset values at the ports
        check("R3 tx_enable", {7'b0, tx_enable}, 8'h00);
        check("R3 tx_mode", {6'b0, tx_mode}, 8'h00);
        check("R3 cfg0", cfg0, 8'h00);
        check("R3 dout_oe", {7'b0, dout_oe}, 8'h00);
        check("R3 tx_data", tx_data, 8'h00);
        rd(0);
        check("R3 status zero", dout, 8'h00);

        // R1, R2: fill and read back every location
        for (int i = 0; i < NB; i++) wr(4 + i, 8'(8'h30 + i * 7));
        for (int i = 0; i < NB; i++) rd(4 + i);
        cyc(1'b1, 1'b0, 5, 8'hEE, 1'b0, 0);   // R2 deselected write
        rd(5);
        check("R2 deselected write", dout, 8'(8'h30 + 7));

        // R12, R4
        wr(1, 8'hA5); wr(2, 8'h5A); rd(1); rd(2);
        wr(3, 8'h01); check("R4 run only", {7'b0, tx_enable}, 8'h00);
        wr(3, 8'h02); check("R4 unmute only", {7'b0, tx_enable}, 8'h00);
        wr(3, 8'h03); check("R4 both set", {7'b0, tx_enable}, 8'h01);

        // R5: legal codes, then the reserved one
        wr(3, 8'h0B); check("R5 mode 2", {6'b0, tx_mode}, 8'h02);
        wr(3, 8'hFC); check("R5 reserved keeps mode", {6'b0, tx_mode}, 8'h02);
        rd(3); check("R5 other bits written", dout, 8'hF8);
        wr(3, 8'h07);

        // R6: status write ignored
        fetch(12);
        wr(0, 8'hFF);
        rd(0); check("R6 status after write", dout, 8'h02);

        // R7: regions
        fetch(0);  rd(0); check("R7 first third", dout, 8'h01);
        fetch(8);  rd(0); check("R7 index 8", dout, 8'h01);
        fetch(9);  rd(0); check("R7 index 9", dout, 8'h02);
        fetch(17); rd(0); check("R7 index 17", dout, 8'h02);
        fetch(18); rd(0); check("R7 index 18", dout, 8'h04);
        fetch(27); rd(0); check("R7 index 27", dout, 8'h04);

        // R10: out of range fetch
        fetch(3);
        fetch(28); check("R10 tx_data hold", tx_data, 8'(8'h30 + 21));
        fetch(31); rd(0); check("R10 status hold", dout, 8'h01);

        // R9: collisions
        for (int k = 0; k < NB; k += 9) begin
            cyc(1'b0, 1'b0, 4 + k, 8'(8'hC0 + k), 1'b1, k);
            check("R9 write first", tx_data, 8'(8'hC0 + k));
        end

        // R11: buffer survives reset
        do_reset();
        fetch(10); check("R11 buffer kept", tx_data, 8'(8'h30 + 70));
        rd(4 + 20);
        check("R3 control cleared", cfg0, 8'h00);

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            int a, fi;
            bit c, r, fe;
            a  = int'($urandom_range(0, 31));
            c  = ($urandom_range(0, 3) == 0);
            r  = $urandom_range(0, 1) == 1;
            fe = $urandom_range(0, 1) == 1;
            fi = ($urandom_range(0, 1) == 1 && a >= 4) ? a - 4 : int'($urandom_range(0, 31));
            cyc(c, r, a, 8'($urandom), fe, fi);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule